// File: doc/BRIEF.md
# Programmable I/O Chip-Select Decoder

This block watches I/O bus cycles and drives one active-low chip-select output whenever a cycle hits a software-programmed address window. The window is a naturally aligned block of 1, 2, 4, 8, 16 or 32 bytes, placed by a 16-bit base address. The base and an 8-bit control byte are loaded through a small byte-wide configuration port. The control byte holds a master enable, separate read and write qualifiers, and a thermometer-coded size field.

The chip select is purely combinational from the bus strobes and address, so it tracks the cycle with no added latency. It releases as soon as the read or write strobe drops. The configuration registers can be read back through the same port. A change takes effect on the clock cycle after the write.

Top module: `iocs_decoder`

## Requirements
- R1: After reset the base register reads 0000h, the control byte reads 00h, and io_cs_n is high.
- R2: A write with cfg_wr_en high loads cfg_wdata into the register picked by cfg_addr (0 = base bits 7:0, 1 = base bits 15:8, 2 = control byte) at the next rising clock edge. Before that edge the old value is still in use. cfg_rdata shows the selected register unchanged. cfg_addr 3 reads 00h and writes to it change nothing.
- R3: While control bit 7 (decode enable) is 0, io_cs_n never goes low.
- R4: Control bit 6 allows chip select on write cycles (io_wr high). When it is 0, a write cycle that hits the window leaves io_cs_n high.
- R5: Control bit 5 allows chip select on read cycles (io_rd high). When it is 0, a read cycle that hits the window leaves io_cs_n high.
- R6: Control bits 4:0 set the window size: 00000 gives 1 byte, 00001 gives 2, 00011 gives 4, 00111 gives 8, 01111 gives 16 and 11111 gives 32. The window starts at the base rounded down to a multiple of its size. Every address inside it hits, and the addresses one below and one above it do not.
- R7: Any other value of bits 4:0 is reserved. It disables decoding, so io_cs_n stays high, and it still reads back exactly as written.
- R8: io_cs_n follows the strobes and address in the same cycle with no clock delay. It is high whenever neither io_rd nor io_wr is high.
- R9: io_cs_n is active low: 0 means selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the selected configuration register |
| io_addr | input | 16 | I/O cycle address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| io_cs_n | output | 1 | Chip select, active low |

## Verification
A wrong base or size register shows up as a window that is shifted, too large or too small. The edge probes, one byte inside and one byte outside the window, catch this on the very next qualified cycle. A wrong qualifier or enable bit shows up as a select on a cycle type that should be ignored, visible on the first strobe of that type. Stale configuration shows as cfg_rdata lagging the write by more than one edge. Since the output has no register, any decode fault appears in the same cycle as the strobe that exposes it.

// File: rtl/iocs_pkg.sv
// Package: shared field positions and helpers for the I/O chip-select decoder.
// Assumes an 8-bit control byte with the size field in its low bits.
package iocs_pkg;
    localparam int CTRL_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int WR_BIT   = 6;
    localparam int RD_BIT   = 5;
    localparam int RANGE_W  = 5;

    // A size code is legal when it is a run of ones from bit 0 (2^k - 1).
    function automatic logic range_legal(input logic [RANGE_W-1:0] code);
        logic [RANGE_W-1:0] nxt;
        nxt = code + 1'b1;
        return (code & nxt) == '0;
    endfunction
endpackage

// File: rtl/iocs_cfg_regs.sv
// Module: configuration register file. It holds the base address as byte
// lanes and the control byte, with byte writes and combinational read-back.
// Assumes ADDR_W is a multiple of 8 and that CFG_AW can index every byte
// lane plus the control byte.
module iocs_cfg_regs
    import iocs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CFG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int CTRL_IDX   = ADDR_BYTES;

    logic [ADDR_W-1:0] base_q;
    logic [CTRL_W-1:0] ctrl_q;

    genvar g;
    generate
        for (g = 0; g < ADDR_BYTES; g++) begin : g_base_lane
            // Purpose: load one byte lane of the base address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q[g*8 +: 8] <= 8'h00;
                end else if (cfg_wr_en && cfg_addr == CFG_AW'(g)) begin
                    base_q[g*8 +: 8] <= cfg_wdata;
                end
            end
        end
    endgenerate

    // Purpose: load the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_wr_en && cfg_addr == CFG_AW'(CTRL_IDX)) begin
            ctrl_q <= cfg_wdata;
        end
    end

    // Purpose: select the register shown on the read-back port.
    always_comb begin
        cfg_rdata = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cfg_addr == CFG_AW'(i)) cfg_rdata = base_q[i*8 +: 8];
        end
        if (cfg_addr == CFG_AW'(CTRL_IDX)) cfg_rdata = ctrl_q;
    end

    assign base_o = base_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/iocs_window_match.sv
// Module: window comparator. It turns the size code into an address mask
// and compares the unmasked address bits against the base. It also flags
// whether the size code is legal. Assumes RANGE_W <= ADDR_W.
module iocs_window_match
    import iocs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [ADDR_W-1:0]  base,
    input  logic [RANGE_W-1:0] range_code,
    output logic               hit,
    output logic               legal
);
    logic [ADDR_W-1:0] ignore_mask;
    logic [ADDR_W-1:0] diff;

    // Purpose: widen the size code into a mask of ignored low bits.
    assign ignore_mask = {{(ADDR_W-RANGE_W){1'b0}}, range_code};
    // Purpose: find differing bits and keep only the ones that are compared.
    assign diff  = (io_addr ^ base) & ~ignore_mask;
    assign hit   = (diff == '0);
    assign legal = range_legal(range_code);
endmodule

// File: rtl/iocs_cycle_qual.sv
// Module: cycle qualifier. It combines the window hit, the legal-size flag,
// the master enable and the per-direction enables into the active-low
// select. Assumes the strobes are active high. The output is combinational.
module iocs_cycle_qual (
    input  logic hit,
    input  logic legal,
    input  logic dec_en,
    input  logic rd_en,
    input  logic wr_en,
    input  logic io_rd,
    input  logic io_wr,
    output logic cs_n
);
    logic kind_ok;

    // Purpose: a cycle type counts only when its own enable is set.
    assign kind_ok = (io_rd && rd_en) || (io_wr && wr_en);
    // Purpose: drive the select low only for a fully qualified hit.
    assign cs_n    = !(dec_en && legal && hit && kind_ok);
endmodule

// File: rtl/iocs_decoder.sv
// Module: top of the programmable I/O chip-select decoder. It wires the
// configuration registers, the window comparator and the cycle qualifier.
// Assumes one decode window and a single clock for the configuration side.
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CFG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              io_cs_n
);
    logic [ADDR_W-1:0] base_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              win_hit;
    logic              win_legal;

    iocs_cfg_regs #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .base_o    (base_q),
        .ctrl_o    (ctrl_q)
    );

    iocs_window_match #(.ADDR_W(ADDR_W)) u_match (
        .io_addr    (io_addr),
        .base       (base_q),
        .range_code (ctrl_q[RANGE_W-1:0]),
        .hit        (win_hit),
        .legal      (win_legal)
    );

    iocs_cycle_qual u_qual (
        .hit    (win_hit),
        .legal  (win_legal),
        .dec_en (ctrl_q[EN_BIT]),
        .rd_en  (ctrl_q[RD_BIT]),
        .wr_en  (ctrl_q[WR_BIT]),
        .io_rd  (io_rd),
        .io_wr  (io_wr),
        .cs_n   (io_cs_n)
    );
endmodule

// File: rtl/iocs_decoder_chk.sv
// Module: assertion checker bound to iocs_decoder. It watches the ports and
// the stored configuration. Assumes the default field layout of iocs_pkg.
module iocs_decoder_chk
    import iocs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CFG_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              io_cs_n,
    input logic [ADDR_W-1:0] base_q,
    input logic [CTRL_W-1:0] ctrl_q
);
    localparam int CTRL_IDX = ADDR_W / 8;

    logic [RANGE_W-1:0] code;
    logic [RANGE_W-1:0] code_inc;
    logic [ADDR_W-1:0]  keep_mask;
    assign code      = ctrl_q[RANGE_W-1:0];
    assign code_inc  = code + 1'b1;
    assign keep_mask = ~{{(ADDR_W-RANGE_W){1'b0}}, code};

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !io_wr) |-> io_cs_n); // R8
    AST_DISABLED_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[EN_BIT] |-> io_cs_n); // R3
    AST_WRITE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && !ctrl_q[WR_BIT]) |-> io_cs_n); // R4
    AST_READ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && !ctrl_q[RD_BIT]) |-> io_cs_n); // R5
    AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((code & code_inc) != '0) |-> io_cs_n); // R7
    AST_SELECT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cs_n |-> (((io_addr ^ base_q) & keep_mask) == '0)); // R6
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == CFG_AW'(CTRL_IDX)) |=> ctrl_q == $past(cfg_wdata)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(base_q) && $stable(ctrl_q))); // R2
endmodule

bind iocs_decoder iocs_decoder_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_cs_n   (io_cs_n),
    .base_q    (base_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_iocs_decoder.sv
// Directed bench for iocs_decoder: one task per scenario, each checking itself.
module tb_iocs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_cs_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_base = 16'h0000;
    logic [7:0]  m_ctrl = 8'h00;

    always #5 clk = ~clk;

    iocs_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_cs_n(io_cs_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Window size in bytes for a size code, 0 for reserved codes.
    function automatic int win_size(input logic [4:0] code);
        case (code)
            5'b00000: return 1;
            5'b00001: return 2;
            5'b00011: return 4;
            5'b00111: return 8;
            5'b01111: return 16;
            5'b11111: return 32;
            default:  return 0;
        endcase
    endfunction

    // Expected select from the requirements: aligned window, enables, active low.
    function automatic logic exp_cs_n(input logic [15:0] a, input logic rd, input logic wr);
        int sz, lo, ai;
        sz = win_size(m_ctrl[4:0]);
        if (sz == 0 || !m_ctrl[7]) return 1'b1;
        lo = (int'(m_base) / sz) * sz;
        ai = int'(a);
        if (ai < lo || ai >= lo + sz) return 1'b1;
        return !((rd && m_ctrl[5]) || (wr && m_ctrl[6]));
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a == 2'd0) m_base[7:0] = d;
        if (a == 2'd1) m_base[15:8] = d;
        if (a == 2'd2) m_ctrl = d;
    endtask

    task automatic setup(input logic [15:0] b, input logic [7:0] c);
        cfg_write(2'd0, b[7:0]);
        cfg_write(2'd1, b[15:8]);
        cfg_write(2'd2, c);
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic rd, input logic wr);
        io_addr = a; io_rd = rd; io_wr = wr;
        #1;
        check(req, {15'd0, io_cs_n}, {15'd0, exp_cs_n(a, rd, wr)});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            cfg_addr = 2'(i); #1;
            check("R1 reset readback", {8'd0, cfg_rdata}, 16'h0000);
        end
        io_addr = 16'h0000; io_rd = 1'b1; #1;
        check("R1 reset cs_n", {15'd0, io_cs_n}, 16'h0001);
        io_rd = 1'b0;
    endtask

    task automatic t_readback;
        // Before the edge the old value still shows; after it the new one.
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'hA3; #1;
        check("R2 old value before edge", {8'd0, cfg_rdata}, 16'h0000);
        @(negedge clk);
        cfg_wr_en = 1'b0; m_ctrl = 8'hA3; #1;
        check("R2 new value after edge", {8'd0, cfg_rdata}, 16'h00A3);
        cfg_write(2'd0, 8'h5C);
        cfg_write(2'd1, 8'hB1);
        cfg_addr = 2'd0; #1; check("R2 base low", {8'd0, cfg_rdata}, 16'h005C);
        cfg_addr = 2'd1; #1; check("R2 base high", {8'd0, cfg_rdata}, 16'h00B1);
        cfg_write(2'd3, 8'hFF);
        cfg_addr = 2'd3; #1; check("R2 spare address reads zero", {8'd0, cfg_rdata}, 16'h0000);
        cfg_addr = 2'd2; #1; check("R2 control unchanged by spare write", {8'd0, cfg_rdata}, 16'h00A3);
        cfg_addr = 2'd0; #1; check("R2 base unchanged by spare write", {8'd0, cfg_rdata}, 16'h005C);
    endtask

    task automatic t_range_sweep;
        for (int k = 0; k <= 5; k++) begin
            logic [4:0] code;
            int sz, lo;
            code = 5'((1 << k) - 1);
            sz = 1 << k;
            setup(16'h3A57, {3'b111, code});
            lo = (16'h3A57 / sz) * sz;
            probe("R6 window low edge rd", 16'(lo), 1'b1, 1'b0);
            probe("R6 window high edge wr", 16'(lo + sz - 1), 1'b0, 1'b1);
            probe("R6 one below window", 16'(lo - 1), 1'b1, 1'b0);
            probe("R6 one above window", 16'(lo + sz), 1'b0, 1'b1);
            probe("R9 base hit selects low", 16'h3A57, 1'b1, 1'b0);
            check("R9 select level", {15'd0, io_cs_n}, 16'h0000);
        end
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic t_reserved;
        for (int c = 0; c < 32; c++) begin
            setup(16'h0100, {3'b111, 5'(c)});
            cfg_addr = 2'd2; #1;
            check("R7 size field reads back", {8'd0, cfg_rdata}, {8'd0, 3'b111, 5'(c)});
            probe("R7 decode at base", 16'h0100, 1'b1, 1'b0);
        end
        io_rd = 1'b0;
    endtask

    task automatic t_qualifiers;
        setup(16'h0240, 8'hC7);   // enable, writes only, 8 bytes
        probe("R4 write-only config write", 16'h0243, 1'b0, 1'b1);
        probe("R5 write-only config read", 16'h0243, 1'b1, 1'b0);
        setup(16'h0240, 8'hA7);   // enable, reads only
        probe("R5 read-only config read", 16'h0244, 1'b1, 1'b0);
        probe("R4 read-only config write", 16'h0244, 1'b0, 1'b1);
        setup(16'h0240, 8'h67);   // both kinds, master off
        probe("R3 disabled read", 16'h0240, 1'b1, 1'b0);
        probe("R3 disabled write", 16'h0240, 1'b0, 1'b1);
        setup(16'h0240, 8'h87);   // master on, no kind enabled
        probe("R3 no kind enabled", 16'h0240, 1'b1, 1'b1);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic t_strobe;
        setup(16'h0300, 8'hEF);   // 16 bytes, both kinds
        probe("R8 read selects", 16'h0305, 1'b1, 1'b0);
        io_rd = 1'b0; #1;
        check("R8 release on strobe drop", {15'd0, io_cs_n}, 16'h0001);
        probe("R8 no strobe in window", 16'h0305, 1'b0, 1'b0);
        io_addr = 16'h0306; io_wr = 1'b1; #1;
        check("R8 same-cycle select", {15'd0, io_cs_n}, 16'h0000);
        io_addr = 16'h0310; #1;
        check("R8 address leaves window", {15'd0, io_cs_n}, 16'h0001);
        io_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_readback;
        t_range_sweep;
        t_reserved;
        t_qualifiers;
        t_strobe;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule